// File: doc/BRIEF.md
# Reciprocal Frequency Counter Core

This block measures how fast an unknown digital signal toggles, relative to the reference clock the block runs on. Two counters run over one shared measurement window. One counts rising edges of the unknown input. The other counts reference clock cycles.

A gate timer sets the nominal window length. The window itself opens and closes only on rising edges of the unknown input. Because of this, the reference count always spans a whole number of input periods. Downstream logic forms the frequency as `res_cycles / res_ref * f_ref`. The relative resolution is the same across the input range, and no frequency or period mode switch is needed. When the input period exceeds the gate length, the result is a single-period measurement.

A measurement starts in one of two ways:
- a one-cycle `arm` pulse, for a single measurement;
- holding `cont_mode` high, for back-to-back windows with no dead time.

The unknown input is asynchronous. It passes through a two-flop synchroniser, and its rising edges are detected in the reference clock domain. A programmable window limit ends a measurement that never completes. It raises a `timeout` pulse and leaves the result registers as they were.

Top module: `recip_freq_meter`

## Requirements
- R1: After reset, `res_valid` and `timeout` are low, and `res_cycles` and `res_ref` read zero.
- R2: Timing references used below:
  - A rising edge of `sig_in` is "sampled at clock k" when `sig_in` is first seen high at rising clock edge k after being low.
  - Arming happens at the clock edge a that samples `arm` (or `cont_mode`) high while the block is idle.
  - The window opens on the first input edge sampled at or after clock a-1. Edges sampled earlier are ignored.
- R3: The window closes on the first input edge k after the opening edge s that satisfies k >= a+gate_len-1. At that point:
  - `res_ref` equals k-s.
  - `res_cycles` equals the number of input edges in (s, k].
  - With `gate_len` of 0, the window closes on the next edge after the opening edge.
- R4: An input whose period exceeds the gate length gives a single-period result: `res_cycles` = 1 and `res_ref` = the period in reference cycles.
- R5: `res_valid` is a one-cycle pulse, high after clock edge k+2 for a closing edge sampled at k. `res_cycles` and `res_ref` change only together with `res_valid`.
- R6: While `cont_mode` is high, the closing edge of one window is the opening edge of the next. The gate timer restarts at the clock edge that issues the result.
- R7: If no closing edge is accepted, `timeout` pulses at clock s+max_win+2, where s is the clock that sampled the opening edge:
  - `res_valid` stays low and the result registers keep their values.
  - A window of exactly `max_win` cycles is still accepted.
- R8: If no opening edge is sampled by clock a+max_win-2, `timeout` pulses at clock a+max_win.
- R9: `arm` is ignored while a measurement is in progress. After a single-shot result or timeout the block is idle, and later input edges produce no events.
- R10: A timeout in continuous mode re-arms at once. When `cont_mode` is low at the clock edge of a result or timeout, the block goes idle after that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Unknown asynchronous input |
| arm | input | 1 | One-cycle request for a single measurement |
| cont_mode | input | 1 | Continuous back-to-back measurement while high |
| gate_len | input | GATE_W | Nominal gate length in reference cycles |
| max_win | input | REF_W | Window limit in reference cycles, non-zero |
| res_valid | output | 1 | One-cycle result strobe |
| res_cycles | output | REF_W | Input edges counted in the last window |
| res_ref | output | REF_W | Reference cycles spanned by the last window |
| timeout | output | 1 | One-cycle pulse: measurement abandoned |

## Verification
Every result and timeout is due at a known clock edge:
- a result two clock edges after the closing input edge is sampled;
- a measuring-state timeout `max_win+2` edges after the opening edge is sampled;
- an armed-state timeout `max_win` edges after arming.

For each scenario, the bench records the clock edge at which each input rise is sampled. It then applies these edge rules to predict every event, with its exact clock number and expected counts, before driving the waveform. The monitor compares each strobe against the head of the queue at the falling edge after the due clock, so a response that comes one cycle early or late fails.

// File: rtl/rfm_pkg.sv
// Shared types for the reciprocal frequency counter.
package rfm_pkg;
    // Measurement sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MEAS  = 2'd2
    } rfm_state_e;

    // Per-cycle control strobes from the sequencer.
    typedef struct packed {
        logic gate_clr;   // restart the gate timer
        logic cnt_clr;    // zero both window counters
        logic stop;       // window closed: latch results
        logic tmo;        // measurement abandoned
    } rfm_ctl_t;
endpackage

// File: rtl/rfm_edge_sync.sv
// Brings an asynchronous input into the clock domain through STAGES flops.
// Flags a rising edge for one cycle.
// Assumes the input stays high and low for at least one clock each.
module rfm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shr;

    // Shift chain: synchroniser stages plus one history flop for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) shr <= '0;
        else        shr <= {shr[DEPTH-2:0], async_in};
    end

    assign rise = shr[DEPTH-2] & ~shr[DEPTH-1];
endmodule

// File: rtl/rfm_gate_timer.sv
// Nominal gate timer.
// Counts reference cycles after a clear and saturates once gate_len is reached.
// Assumes gate_len is held stable while a measurement runs.
module rfm_gate_timer #(
    parameter int GATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [GATE_W-1:0] gate_len,
    output logic              done
);
    logic [GATE_W-1:0] cnt;

    assign done = (cnt >= gate_len);

    // Count up from a clear until the programmed length is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (clr)         cnt <= '0;
        else if (en && !done) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rfm_win_counters.sv
// Window counters and result registers.
// ref_cnt counts reference cycles and cyc_cnt counts input edges.
// Both are latched (+1, covering the closing cycle and edge) on stop.
// Assumes max_win is non-zero and held stable during a measurement.
module rfm_win_counters #(
    parameter int REF_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             sig_step,
    input  logic             latch,
    input  logic [REF_W-1:0] max_win,
    output logic             win_full,
    output logic [REF_W-1:0] res_cycles,
    output logic [REF_W-1:0] res_ref
);
    localparam int EXT_W = REF_W + 1;

    logic [REF_W-1:0] ref_cnt;
    logic [REF_W-1:0] cyc_cnt;
    logic [EXT_W-1:0] ref_next;

    assign ref_next = {1'b0, ref_cnt} + 1'b1;
    assign win_full = (ref_next == {1'b0, max_win});

    // Reference cycle counter: runs whenever a measurement is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)   ref_cnt <= '0;
        else if (clr) ref_cnt <= '0;
        else if (run) ref_cnt <= ref_next[REF_W-1:0];
    end

    // Input edge counter: counts edges inside an open window.
    always_ff @(posedge clk) begin
        if (!rst_n)        cyc_cnt <= '0;
        else if (clr)      cyc_cnt <= '0;
        else if (sig_step) cyc_cnt <= cyc_cnt + 1'b1;
    end

    // Result registers: capture both counts on the closing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_cycles <= '0;
            res_ref    <= '0;
        end else if (latch) begin
            res_cycles <= cyc_cnt + 1'b1;
            res_ref    <= ref_next[REF_W-1:0];
        end
    end
endmodule

// File: rtl/rfm_window_ctrl.sv
// Measurement sequencer: idle -> armed (gate running, waiting for the opening
// edge) -> measuring (waiting for an edge after the gate has elapsed).
// Issues clear/stop/timeout strobes and registers the valid and timeout
// pulses. Assumes rise is a single-cycle strobe.
module rfm_window_ctrl
    import rfm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     arm,
    input  logic     cont_mode,
    input  logic     rise,
    input  logic     gate_done,
    input  logic     win_full,
    output rfm_ctl_t ctl,
    output logic     busy,
    output logic     sig_step,
    output logic     res_valid,
    output logic     timeout
);
    rfm_state_e state, state_nx;

    // Next-state and strobe decode.
    always_comb begin
        state_nx = state;
        ctl      = '0;
        sig_step = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (arm || cont_mode) begin
                    state_nx     = ST_ARMED;
                    ctl.gate_clr = 1'b1;
                    ctl.cnt_clr  = 1'b1;
                end
            end
            ST_ARMED: begin
                if (rise) begin
                    state_nx    = ST_MEAS;
                    ctl.cnt_clr = 1'b1;
                end else if (win_full) begin
                    ctl.tmo = 1'b1;
                    if (cont_mode) begin
                        ctl.gate_clr = 1'b1;
                        ctl.cnt_clr  = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_MEAS: begin
                if (rise && gate_done) begin
                    ctl.stop = 1'b1;
                    if (cont_mode) begin
                        ctl.gate_clr = 1'b1;
                        ctl.cnt_clr  = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end else if (win_full) begin
                    ctl.tmo = 1'b1;
                    if (cont_mode) begin
                        state_nx     = ST_ARMED;
                        ctl.gate_clr = 1'b1;
                        ctl.cnt_clr  = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end else if (rise) begin
                    sig_step = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign busy = (state != ST_IDLE);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Registered result and timeout strobes, aligned with the result latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            res_valid <= ctl.stop;
            timeout   <= ctl.tmo;
        end
    end
endmodule

// File: rtl/recip_freq_meter.sv
// Reciprocal frequency counter core.
// Counts input edges and reference cycles over a window that opens and closes
// on input edges, with the nominal length set by a gate timer.
// Assumes gate_len and max_win change only while idle.
module recip_freq_meter
    import rfm_pkg::*;
#(
    parameter int REF_W     = 24,
    parameter int GATE_W    = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic              arm,
    input  logic              cont_mode,
    input  logic [GATE_W-1:0] gate_len,
    input  logic [REF_W-1:0]  max_win,
    output logic              res_valid,
    output logic [REF_W-1:0]  res_cycles,
    output logic [REF_W-1:0]  res_ref,
    output logic              timeout
);
    logic     rise;
    logic     gate_done;
    logic     win_full;
    logic     busy;
    logic     sig_step;
    rfm_ctl_t ctl;

    rfm_edge_sync #(.STAGES(SYNC_DEPTH)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sig_in),
        .rise     (rise)
    );

    rfm_gate_timer #(.GATE_W(GATE_W)) gate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl.gate_clr),
        .en       (busy),
        .gate_len (gate_len),
        .done     (gate_done)
    );

    rfm_win_counters #(.REF_W(REF_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (ctl.cnt_clr),
        .run        (busy),
        .sig_step   (sig_step),
        .latch      (ctl.stop),
        .max_win    (max_win),
        .win_full   (win_full),
        .res_cycles (res_cycles),
        .res_ref    (res_ref)
    );

    rfm_window_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .cont_mode (cont_mode),
        .rise      (rise),
        .gate_done (gate_done),
        .win_full  (win_full),
        .ctl       (ctl),
        .busy      (busy),
        .sig_step  (sig_step),
        .res_valid (res_valid),
        .timeout   (timeout)
    );
endmodule

// File: rtl/recip_freq_meter_chk.sv
// Port-level property checker for recip_freq_meter, attached by bind.
module recip_freq_meter_chk #(
    parameter int REF_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REF_W-1:0] max_win,
    input logic             res_valid,
    input logic             timeout,
    input logic [REF_W-1:0] res_cycles,
    input logic [REF_W-1:0] res_ref
);
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_cycles) && $stable(res_ref)));

    assert_valid_xor_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && timeout));

    assert_ref_within_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_ref <= max_win && res_ref != '0));

    assert_cycles_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_cycles != '0 && res_cycles <= res_ref));
endmodule

bind recip_freq_meter recip_freq_meter_chk #(.REF_W(REF_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .max_win    (max_win),
    .res_valid  (res_valid),
    .timeout    (timeout),
    .res_cycles (res_cycles),
    .res_ref    (res_ref)
);

// File: tb/recip_freq_meter_tb_top.sv
// Scoreboard bench: each scenario predicts its events from the recorded input
// edges and pushes them into a queue; the monitor pops and compares.
module recip_freq_meter_tb_top;
    localparam int REF_W  = 24;
    localparam int GATE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sig_in = 1'b0;
    logic              arm = 1'b0;
    logic              cont_mode = 1'b0;
    logic [GATE_W-1:0] gate_len = '0;
    logic [REF_W-1:0]  max_win = '0;
    logic              res_valid;
    logic              timeout;
    logic [REF_W-1:0]  res_cycles;
    logic [REF_W-1:0]  res_ref;

    typedef struct {
        bit     is_tmo;
        longint cyc_cnt;
        longint ref_cnt;
        longint at;
        string  req;
    } exp_t;

    exp_t   sb[$];
    longint rises[$];
    longint cyc = 0;
    longint last_cyc = 0;
    longint last_ref = 0;
    int     checks = 0;
    int     errors = 0;
    bit     finished = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    recip_freq_meter #(.REF_W(REF_W), .GATE_W(GATE_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_in     (sig_in),
        .arm        (arm),
        .cont_mode  (cont_mode),
        .gate_len   (gate_len),
        .max_win    (max_win),
        .res_valid  (res_valid),
        .res_cycles (res_cycles),
        .res_ref    (res_ref),
        .timeout    (timeout)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint first_from(input longint lo);
        foreach (rises[i]) if (rises[i] >= lo) return rises[i];
        return -1;
    endfunction

    function automatic longint edges_in(input longint s, input longint k);
        longint n = 0;
        foreach (rises[i]) if (rises[i] > s && rises[i] <= k) n++;
        return n;
    endfunction

    function automatic void push_ev(input bit tmo, input longint c, input longint r,
                                    input longint at, input string req);
        exp_t e;
        e.is_tmo = tmo; e.cyc_cnt = c; e.ref_cnt = r; e.at = at; e.req = req;
        sb.push_back(e);
    endfunction

    // Event prediction from the edge rules of the requirements (R2, R3, R6-R10).
    function automatic void predict(input string req, input longint a0, input longint d0,
                                    input longint g, input longint m);
        longint a = a0, s = 0, k, p;
        bit armed = 1'b1;
        while (1) begin
            if (armed) begin
                k = first_from(a - 1);
                if (k >= 0 && k <= a + m - 2) begin
                    s = k; armed = 1'b0;
                end else begin
                    p = a + m;
                    push_ev(1'b1, 0, 0, p, "R8");
                    if (p >= d0) break;
                    a = p;
                end
            end else begin
                k = first_from((s + 1 > a + g - 1) ? s + 1 : a + g - 1);
                if (k >= 0 && k - s <= m) begin
                    p = k + 2;
                    push_ev(1'b0, edges_in(s, k), k - s, p, req);
                    if (p >= d0) break;
                    s = k; a = p;
                end else begin
                    p = s + m + 2;
                    push_ev(1'b1, 0, 0, p, "R7");
                    if (p >= d0) break;
                    a = p; armed = 1'b1;
                end
            end
        end
    endfunction

    function automatic bit wave(input int t, input int fd, input int per, input int nper);
        if (t < fd || t >= fd + nper * per) return 1'b0;
        return ((t - fd) % per) < (per / 2);
    endfunction

    // Driver: predict every event of one scenario, then play the waveform.
    task automatic scenario(input string req, input int per, input int fd, input int nper,
                            input int ts, input int ts2, input bit cont, input int td,
                            input int len, input int g, input int m);
        longint base, a0, d0;
        bit prev = 1'b0, cur;
        gate_len = GATE_W'(g);
        max_win  = REF_W'(m);
        base = cyc;
        rises.delete();
        for (int t = 1; t <= len; t++) begin
            cur = wave(t, fd, per, nper);
            if (cur && !prev) rises.push_back(base + t);
            prev = cur;
        end
        a0 = base + ts;
        d0 = cont ? base + td : a0 + 1;
        predict(req, a0, d0, g, m);
        for (int t = 1; t <= len; t++) begin
            sig_in    = wave(t, fd, per, nper);
            arm       = !cont && (t == ts || t == ts2);
            cont_mode = cont && t >= ts && t < td;
            @(negedge clk);
        end
        sig_in = 1'b0; arm = 1'b0; cont_mode = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check(sb.size() == 0, req, "events still pending after scenario", sb.size(), 0);
        sb.delete();
    endtask

    // Monitor: compare each strobe with the head of the scoreboard.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (res_valid || timeout)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected event at cycle", cyc, -1);
            end else begin
                e = sb.pop_front();
                check(cyc == e.at, e.req, "event cycle", cyc, e.at);
                if (e.is_tmo) begin
                    check(timeout && !res_valid, e.req, "timeout strobe", timeout, 1);
                    check(res_cycles == last_cyc, "R7", "cycles kept on timeout", res_cycles, last_cyc);
                    check(res_ref == last_ref, "R7", "ref kept on timeout", res_ref, last_ref);
                end else begin
                    check(res_valid && !timeout, e.req, "valid strobe", res_valid, 1);
                    check(res_cycles == e.cyc_cnt, e.req, "res_cycles", res_cycles, e.cyc_cnt);
                    check(res_ref == e.ref_cnt, e.req, "res_ref", res_ref, e.ref_cnt);
                    last_cyc = e.cyc_cnt;
                    last_ref = e.ref_cnt;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!res_valid, "R1", "res_valid after reset", res_valid, 0);
        check(!timeout, "R1", "timeout after reset", timeout, 0);
        check(res_cycles == 0, "R1", "res_cycles after reset", res_cycles, 0);
        check(res_ref == 0, "R1", "res_ref after reset", res_ref, 0);
        // R3: several cycles per gate
        scenario("R3", 10, 5, 10, 2, 0, 1'b0, 0, 130, 40, 300);
        // R2: edge sampled one clock before arming opens the window
        scenario("R2", 7, 9, 8, 10, 0, 1'b0, 0, 80, 30, 300);
        // R2: edge sampled two clocks before arming is ignored
        scenario("R2", 7, 8, 8, 10, 0, 1'b0, 0, 80, 30, 300);
        // R4: period longer than the gate
        scenario("R4", 120, 3, 3, 1, 0, 1'b0, 0, 300, 40, 300);
        // R3: zero gate length closes on the next edge
        scenario("R3", 6, 4, 4, 1, 0, 1'b0, 0, 60, 0, 300);
        // R6 and R10: continuous windows, then mode dropped
        scenario("R6", 9, 4, 30, 1, 0, 1'b1, 200, 300, 40, 300);
        // R7: window of exactly max_win accepted
        scenario("R7", 60, 3, 3, 1, 0, 1'b0, 0, 200, 40, 60);
        // R7: window one cycle longer than max_win times out
        scenario("R7", 61, 3, 3, 1, 0, 1'b0, 0, 200, 40, 60);
        // R7: single edge then silence
        scenario("R7", 8, 5, 1, 1, 0, 1'b0, 0, 120, 20, 50);
        // R8: no edge at all after arming
        scenario("R8", 8, 1, 0, 1, 0, 1'b0, 0, 80, 20, 40);
        // R10: continuous mode re-arms after each armed timeout
        scenario("R10", 8, 1, 0, 1, 0, 1'b1, 100, 150, 20, 30);
        // R9: arm during measurement is ignored
        scenario("R9", 10, 5, 12, 2, 20, 1'b0, 0, 160, 60, 300);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule